// File: doc/BRIEF.md
# Flash Self-Programming Command Sequencer

This block lets running software reprogram its own flash memory. Software first writes a command into an 8-bit control register. It then raises a store strobe, which must arrive inside a short window after that write. The block recognises four actions:

- loading one word into a page-sized staging buffer,
- erasing a page,
- writing the staging buffer into a page,
- re-opening the main (read-while-write) region.

Erase and write take a fixed number of cycles. The flash is split into two regions by page number. Low pages form the read-while-write region, which stays unreadable while it is being changed. High pages form the no-read-while-write region. Changing a high page stalls the processor through a halt output. A level interrupt tells software that the sequencer is free again, so it does not have to poll.

The flash array here is a behavioural memory with a read port. Address pointers are word addresses: the upper bits select the page and the lower bits select the word within the page.

Top module: `fsp_seq`

## Requirements
- R1: The control register reads back as follows: bit 0 is the enable, bit 1 is erase, bit 2 is write, bit 4 is re-enable, bit 6 is the busy flag and bit 7 is the interrupt enable. Bits 3 and 5 read as zero. A write arms a command only when its low six bits are one of these codes: 000001 (buffer load), 000011 (erase), 000101 (write) or 010001 (re-enable). Any other value reads back with the enable bit and bits 0 to 5 all zero.
- R2: After the control register is written in clock cycle k, a store strobe in cycles k+1 to k+4 executes the command. If no strobe arrives by then, the command is dropped at the end of cycle k+4 and the enable bit reads 0.
- R3: An executed buffer load stores the data word in the staging buffer at the word field of the pointer. The page field is ignored.
- R4: An erase sets every word of the addressed page to all ones. Only the page field is used: the word field and the data word have no effect, and other pages are unchanged.
- R5: A page write copies the staging buffer into the addressed page. Afterwards the buffer holds all ones again.
- R6: An erase or write keeps the enable bit set for OP_CYCLES cycles after the strobe edge, then clears it. The command bits clear at the same time.
- R7: An erase or write on a page below RWW_PAGES sets the busy flag. While the busy flag is set, reads of low pages return zero with rd_ok low, and reads of high pages stay valid. The halt output stays low.
- R8: An erase or write on a page at or above RWW_PAGES drives cpu_halt high for exactly the operation's duration. The busy flag stays low.
- R9: irq is high whenever the interrupt enable is 1 and the enable bit is 0.
- R10: An executed re-enable clears the busy flag, which stays set after a low-region operation completes until then. It also resets the staging buffer to all ones.
- R11: Control register writes during an erase or write are ignored, including the interrupt enable. The register keeps reading back the running command.
- R12: After reset, the control register reads 0, irq, rww_busy and cpu_halt are low, every flash word and every buffer word is all ones, and reads are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register read value |
| spm_strobe | input | 1 | Store strobe that executes the armed command |
| ptr_addr | input | log2(NUM_PAGES*PAGE_WORDS) | Word pointer: page in the upper bits, word in the lower bits |
| spm_data | input | WORD_W | Data word for buffer loads |
| rd_addr | input | log2(NUM_PAGES*PAGE_WORDS) | Flash read address |
| rd_data | output | WORD_W | Flash read data, zero when blocked |
| rd_ok | output | 1 | Read not blocked |
| rww_busy | output | 1 | Low region under change or not yet re-enabled |
| cpu_halt | output | 1 | Processor stall during high-region operations |
| irq | output | 1 | Level interrupt: sequencer ready |

## Verification
The bench builds the block with four pages of four words, two pages in each region, and an operation latency of 12 cycles. This lets a single short run reach both regions with page contents that can be checked word by word. It also lets the bench count the operation length exactly and still finish quickly. The strobe window keeps its default of four, so the bench probes both the last accepted cycle and the first rejected one.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FILL,
        OP_ERASE,
        OP_WRITE,
        OP_REEN
    } op_e;

    localparam int EN_BIT   = 0;
    localparam int BUSY_BIT = 6;
    localparam int IE_BIT   = 7;

    // Actions the sequencer hands to the storage side.
    typedef struct packed {
        logic fill;      // load one staging word
        logic clr_buf;   // reset staging buffer
        logic commit;    // final cycle of erase/write
        logic is_write;  // commit copies buffer (else erases)
    } act_t;

    function automatic op_e decode_cmd(input logic [7:0] v);
        case (v[5:0])
            6'b000001: return OP_FILL;
            6'b000011: return OP_ERASE;
            6'b000101: return OP_WRITE;
            6'b010001: return OP_REEN;
            default:   return OP_NONE;
        endcase
    endfunction

    function automatic logic [5:0] op_bits(input op_e o);
        case (o)
            OP_FILL:  return 6'b000001;
            OP_ERASE: return 6'b000011;
            OP_WRITE: return 6'b000101;
            OP_REEN:  return 6'b010001;
            default:  return 6'b000000;
        endcase
    endfunction

endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
    import fsp_pkg::*;
#(
    parameter int PAGE_BITS = 4,
    parameter int RWW_PAGES = 12,
    parameter int OP_CYCLES = 64,
    parameter int WINDOW    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic [7:0]           ctl_wdata,
    output logic [7:0]           ctl_rdata,
    input  logic                 spm_strobe,
    input  logic [PAGE_BITS-1:0] ptr_page,
    output logic [PAGE_BITS-1:0] tgt_page,
    output act_t                 act,
    output logic                 rww_busy,
    output logic                 cpu_halt,
    output logic                 irq
);
    localparam int CNT_W = $clog2(OP_CYCLES + 1);
    localparam int WIN_W = $clog2(WINDOW + 1);
    localparam logic [PAGE_BITS:0] RWW_LIM = (PAGE_BITS + 1)'(RWW_PAGES);

    op_e              armed;
    logic             ie;
    logic             run;
    logic [CNT_W-1:0] op_cnt;
    logic [WIN_W-1:0] win;
    logic             accept;
    logic             last;
    logic             low_region;

    assign accept     = !run && !ctl_we && spm_strobe && (win != '0) && (armed != OP_NONE);
    assign last       = run && (op_cnt == CNT_W'(1));
    assign low_region = {1'b0, ptr_page} < RWW_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= OP_NONE;
            ie       <= 1'b0;
            run      <= 1'b0;
            op_cnt   <= '0;
            win      <= '0;
            tgt_page <= '0;
            rww_busy <= 1'b0;
            cpu_halt <= 1'b0;
        end else if (run) begin
            if (last) begin
                run      <= 1'b0;
                cpu_halt <= 1'b0;
                armed    <= OP_NONE;
            end else begin
                op_cnt <= op_cnt - CNT_W'(1);
            end
        end else if (ctl_we) begin
            ie    <= ctl_wdata[IE_BIT];
            armed <= decode_cmd(ctl_wdata);
            win   <= WIN_W'(WINDOW);
        end else if (accept) begin
            win <= '0;
            case (armed)
                OP_ERASE, OP_WRITE: begin
                    run      <= 1'b1;
                    op_cnt   <= CNT_W'(OP_CYCLES);
                    tgt_page <= ptr_page;
                    if (low_region) rww_busy <= 1'b1;
                    else            cpu_halt <= 1'b1;
                end
                OP_REEN: begin
                    rww_busy <= 1'b0;
                    armed    <= OP_NONE;
                end
                default: armed <= OP_NONE;
            endcase
        end else if (win != '0) begin
            win <= win - WIN_W'(1);
            if (win == WIN_W'(1)) armed <= OP_NONE;
        end
    end

    always_comb begin
        act          = '0;
        act.fill     = accept && (armed == OP_FILL);
        act.clr_buf  = accept && (armed == OP_REEN);
        act.commit   = last;
        act.is_write = (armed == OP_WRITE);
    end

    assign ctl_rdata = {ie, rww_busy, op_bits(armed)};
    assign irq       = ie && (armed == OP_NONE);

endmodule

// File: rtl/fsp_store.sv
module fsp_store
    import fsp_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int PAGE_WORDS = 32,
    parameter int NUM_PAGES  = 16,
    parameter int RWW_PAGES  = 12
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  act_t                                        act,
    input  logic [$clog2(NUM_PAGES)-1:0]                tgt_page,
    input  logic [$clog2(PAGE_WORDS)-1:0]               fill_word,
    input  logic [WORD_W-1:0]                           fill_data,
    input  logic                                        rww_busy,
    input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]     rd_addr,
    output logic [WORD_W-1:0]                           rd_data,
    output logic                                        rd_ok
);
    localparam int PAGE_BITS = $clog2(NUM_PAGES);
    localparam int WORD_BITS = $clog2(PAGE_WORDS);
    localparam int AW        = PAGE_BITS + WORD_BITS;
    localparam int DEPTH     = NUM_PAGES * PAGE_WORDS;
    localparam logic [PAGE_BITS:0] RWW_LIM = (PAGE_BITS + 1)'(RWW_PAGES);

    logic [WORD_W-1:0] mem  [DEPTH];
    logic [WORD_W-1:0] sbuf [PAGE_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)      mem[i]  <= '1;
            for (int w = 0; w < PAGE_WORDS; w++) sbuf[w] <= '1;
        end else begin
            if (act.fill) sbuf[fill_word] <= fill_data;
            if (act.commit) begin
                for (int w = 0; w < PAGE_WORDS; w++)
                    mem[{tgt_page, WORD_BITS'(w)}] <= act.is_write ? sbuf[w] : '1;
            end
            if (act.clr_buf || (act.commit && act.is_write)) begin
                for (int w = 0; w < PAGE_WORDS; w++) sbuf[w] <= '1;
            end
        end
    end

    logic [PAGE_BITS-1:0] rd_page;
    assign rd_page = rd_addr[AW-1 -: PAGE_BITS];
    assign rd_ok   = !(rww_busy && ({1'b0, rd_page} < RWW_LIM));
    assign rd_data = rd_ok ? mem[rd_addr] : '0;

endmodule

// File: rtl/fsp_seq.sv
module fsp_seq
    import fsp_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int PAGE_WORDS = 32,
    parameter int NUM_PAGES  = 16,
    parameter int RWW_PAGES  = 12,
    parameter int OP_CYCLES  = 64,
    parameter int WINDOW     = 4
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    ctl_we,
    input  logic [7:0]                              ctl_wdata,
    output logic [7:0]                              ctl_rdata,
    input  logic                                    spm_strobe,
    input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0] ptr_addr,
    input  logic [WORD_W-1:0]                       spm_data,
    input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0] rd_addr,
    output logic [WORD_W-1:0]                       rd_data,
    output logic                                    rd_ok,
    output logic                                    rww_busy,
    output logic                                    cpu_halt,
    output logic                                    irq
);
    localparam int PAGE_BITS = $clog2(NUM_PAGES);
    localparam int WORD_BITS = $clog2(PAGE_WORDS);
    localparam int AW        = PAGE_BITS + WORD_BITS;

    act_t                 act;
    logic [PAGE_BITS-1:0] tgt_page;

    fsp_ctrl #(
        .PAGE_BITS(PAGE_BITS),
        .RWW_PAGES(RWW_PAGES),
        .OP_CYCLES(OP_CYCLES),
        .WINDOW   (WINDOW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .spm_strobe(spm_strobe),
        .ptr_page  (ptr_addr[AW-1 -: PAGE_BITS]),
        .tgt_page  (tgt_page),
        .act       (act),
        .rww_busy  (rww_busy),
        .cpu_halt  (cpu_halt),
        .irq       (irq)
    );

    fsp_store #(
        .WORD_W    (WORD_W),
        .PAGE_WORDS(PAGE_WORDS),
        .NUM_PAGES (NUM_PAGES),
        .RWW_PAGES (RWW_PAGES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .tgt_page (tgt_page),
        .fill_word(ptr_addr[WORD_BITS-1:0]),
        .fill_data(spm_data),
        .rww_busy (rww_busy),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_ok    (rd_ok)
    );

endmodule

// File: rtl/fsp_seq_chk.sv
module fsp_seq_chk #(
    parameter int WINDOW = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic [7:0] ctl_rdata,
    input logic       rww_busy,
    input logic       cpu_halt,
    input logic       irq,
    input logic       rd_ok
);
    localparam int SW = $clog2(WINDOW + 2) + 1;
    logic [SW-1:0] since_we;

    always_ff @(posedge clk) begin
        if (rst)                            since_we <= '0;
        else if (ctl_we)                    since_we <= SW'(1);
        else if (since_we != '0 && since_we <= SW'(WINDOW)) since_we <= since_we + SW'(1);
    end

    // R2: an operation only starts from a strobe inside the window
    assert_strobe_window_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_halt) || $rose(rww_busy)) |->
            ($past(since_we) != '0 && $past(since_we) <= SW'(WINDOW)));

    // R8: halt only while the enable bit is up, never with busy rising
    assert_halt_with_enable_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_halt |-> ctl_rdata[0]);

    // R7: a low-region operation never raises halt
    assert_rww_no_halt_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rww_busy) |-> !cpu_halt);

    // R7: blocked reads only while busy
    assert_block_needs_busy_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_ok |-> rww_busy);

    // R9: interrupt follows completion when enabled
    assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl_rdata[0]) && ctl_rdata[7]) |-> irq);

    // R11: interrupt enable frozen during a halting operation
    assert_ie_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && $past(cpu_halt)) |-> $stable(ctl_rdata[7]));

endmodule

bind fsp_seq fsp_seq_chk #(.WINDOW(WINDOW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .ctl_rdata(ctl_rdata),
    .rww_busy (rww_busy),
    .cpu_halt (cpu_halt),
    .irq      (irq),
    .rd_ok    (rd_ok)
);

// File: tb/tb_fsp_seq.sv
`timescale 1ns/1ps
module tb_fsp_seq;
    localparam int WW  = 16;
    localparam int PWS = 4;
    localparam int NP  = 4;
    localparam int RP  = 2;
    localparam int OPC = 12;
    localparam int WIN = 4;
    localparam int AW  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_we = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic [7:0]    ctl_rdata;
    logic          spm_strobe = 1'b0;
    logic [AW-1:0] ptr_addr = '0;
    logic [WW-1:0] spm_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [WW-1:0] rd_data;
    logic          rd_ok, rww_busy, cpu_halt, irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fsp_seq #(
        .WORD_W(WW), .PAGE_WORDS(PWS), .NUM_PAGES(NP),
        .RWW_PAGES(RP), .OP_CYCLES(OPC), .WINDOW(WIN)
    ) dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .spm_strobe(spm_strobe), .ptr_addr(ptr_addr),
        .spm_data(spm_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_ok(rd_ok), .rww_busy(rww_busy), .cpu_halt(cpu_halt), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic strobe(input int d, input logic [AW-1:0] a, input logic [WW-1:0] dat);
        repeat (d - 1) @(negedge clk);
        ptr_addr = a; spm_data = dat; spm_strobe = 1'b1;
        @(negedge clk);
        spm_strobe = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] v, input int d, input logic [AW-1:0] a, input logic [WW-1:0] dat);
        wr_ctl(v);
        strobe(d, a, dat);
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (ctl_rdata[0] && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [WW-1:0] exp, input bit ok_exp, input string req);
        rd_addr = a;
        #0.5;
        chk(rd_data == exp, req, rd_data, exp);
        chk(rd_ok == ok_exp, req, rd_ok, ok_exp);
    endtask

    task automatic t_reset;
        chk(ctl_rdata == 8'h00, "R12 ctl", ctl_rdata, 0);
        chk({irq, rww_busy, cpu_halt} == 3'b000, "R12 outs", {irq, rww_busy, cpu_halt}, 0);
        rd_chk(4'h0, 16'hFFFF, 1'b1, "R12 flash");
        rd_chk(4'hF, 16'hFFFF, 1'b1, "R12 flash");
    endtask

    task automatic t_decode;
        wr_ctl(8'h01);
        chk(ctl_rdata == 8'h01, "R1 armed load", ctl_rdata, 8'h01);
        repeat (WIN) @(negedge clk);
        chk(ctl_rdata == 8'h00, "R2 expiry", ctl_rdata, 0);
        wr_ctl(8'h07);
        chk(ctl_rdata == 8'h00, "R1 bad code", ctl_rdata, 0);
        repeat (WIN) @(negedge clk);
    endtask

    task automatic t_load_nrww_write;
        int n;
        cmd(8'h01, 1, 4'h0, 16'hA000);
        cmd(8'h01, 4, 4'hD, 16'hA001);          // R3 page field ignored, last window cycle
        cmd(8'h01, 5, 4'h2, 16'hBAD2);          // R2 too late: dropped
        chk(ctl_rdata[0] == 1'b0, "R2 late drop", ctl_rdata, 0);
        cmd(8'h01, 2, 4'h3, 16'hA003);
        cmd(8'h05, 1, 4'h8, 16'h0000);          // write page 2 (high region)
        chk(cpu_halt == 1'b1, "R8 halt", cpu_halt, 1);
        chk(rww_busy == 1'b0, "R8 no busy", rww_busy, 0);
        chk(ctl_rdata == 8'h05, "R1 write readback", ctl_rdata, 8'h05);
        wr_ctl(8'h83);                          // R11 ignored
        chk(ctl_rdata == 8'h05, "R11 readback", ctl_rdata, 8'h05);
        chk(irq == 1'b0, "R11 ie kept", irq, 0);
        wait_done(n);
        chk(n == OPC - 1, "R6 duration", n, OPC - 1);
        chk(cpu_halt == 1'b0, "R8 halt end", cpu_halt, 0);
        chk(ctl_rdata == 8'h00, "R6 clear", ctl_rdata, 0);
        rd_chk(4'h8, 16'hA000, 1'b1, "R3 w0");
        rd_chk(4'h9, 16'hA001, 1'b1, "R3 w1");
        rd_chk(4'hA, 16'hFFFF, 1'b1, "R2 w2 untouched");
        rd_chk(4'hB, 16'hA003, 1'b1, "R5 w3");
    endtask

    task automatic t_buf_autoclear;
        int n;
        cmd(8'h05, 1, 4'h8, 16'h0000);
        wait_done(n);
        rd_chk(4'h8, 16'hFFFF, 1'b1, "R5 buffer cleared");
        rd_chk(4'hB, 16'hFFFF, 1'b1, "R5 buffer cleared");
    endtask

    task automatic t_rww;
        int n;
        cmd(8'h01, 1, 4'hB, 16'hC0DE);          // for page 2 (high)
        cmd(8'h05, 1, 4'h8, 16'h0000);
        wait_done(n);
        cmd(8'h01, 1, 4'h1, 16'h1111);
        cmd(8'h01, 1, 4'h2, 16'h2222);
        cmd(8'h05, 1, 4'h0, 16'h0000);          // write page 0 (low region)
        chk(rww_busy == 1'b1, "R7 busy", rww_busy, 1);
        chk(cpu_halt == 1'b0, "R7 no halt", cpu_halt, 0);
        chk(ctl_rdata == 8'h45, "R7 readback", ctl_rdata, 8'h45);
        rd_chk(4'h1, 16'h0000, 1'b0, "R7 blocked");
        rd_chk(4'hB, 16'hC0DE, 1'b1, "R7 high readable");
        wait_done(n);
        chk(n == OPC, "R6 duration low", n, OPC);
        chk(ctl_rdata == 8'h40, "R10 busy held", ctl_rdata, 8'h40);
        rd_chk(4'h2, 16'h0000, 1'b0, "R10 still blocked");
        cmd(8'h11, 3, 4'h0, 16'h0000);
        chk(rww_busy == 1'b0, "R10 reopen", rww_busy, 0);
        rd_chk(4'h1, 16'h1111, 1'b1, "R5 low page");
        rd_chk(4'h2, 16'h2222, 1'b1, "R5 low page");
        rd_chk(4'h0, 16'hFFFF, 1'b1, "R5 low page");
        // page 1 then erase page 0 with junk word field and data
        cmd(8'h01, 1, 4'h3, 16'h3333);
        cmd(8'h05, 1, 4'h4, 16'h0000);
        wait_done(n);
        cmd(8'h11, 1, 4'h0, 16'h0000);
        cmd(8'h03, 1, 4'h3, 16'hDEAD);
        wait_done(n);
        cmd(8'h11, 1, 4'h0, 16'h0000);
        rd_chk(4'h1, 16'hFFFF, 1'b1, "R4 erased");
        rd_chk(4'h2, 16'hFFFF, 1'b1, "R4 erased");
        rd_chk(4'h7, 16'h3333, 1'b1, "R4 other page");
        // R10 buffer reset by re-enable
        cmd(8'h01, 1, 4'h0, 16'h7777);
        cmd(8'h11, 1, 4'h0, 16'h0000);
        cmd(8'h05, 1, 4'h4, 16'h0000);
        wait_done(n);
        cmd(8'h11, 1, 4'h0, 16'h0000);
        rd_chk(4'h4, 16'hFFFF, 1'b1, "R10 buffer reset");
    endtask

    task automatic t_irq;
        int n;
        wr_ctl(8'h80);
        chk(irq == 1'b1, "R9 idle irq", irq, 1);
        wr_ctl(8'h81);
        chk(irq == 1'b0, "R9 armed", irq, 0);
        repeat (WIN - 1) @(negedge clk);
        chk(irq == 1'b0, "R2 window edge", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R9 after drop", irq, 1);
        cmd(8'h85, 1, 4'hC, 16'h0000);
        chk(irq == 1'b0, "R9 busy op", irq, 0);
        chk(ctl_rdata == 8'h85, "R1 ie readback", ctl_rdata, 8'h85);
        wait_done(n);
        chk(irq == 1'b1, "R9 done", irq, 1);
        wr_ctl(8'h00);
        chk(irq == 1'b0, "R9 off", irq, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog all act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_load_nrww_write();
        t_buf_autoclear();
        t_rww();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule